// File: doc/BRIEF.md
# Standalone Error Record Viewer

This block sits beside a memory tester and keeps the error records the tester produces, so that they can be read later without a host computer. Each record carries five items: a running error number, the failing address, the cycle count at which the failure happened, the wrong data that was read back, and a code for the test phase that was running. Records arrive on a valid/ready input. They are kept in a small buffer in arrival order. The input never stalls the tester. Records that arrive when the buffer is full are discarded, and a sticky overflow flag is raised.

Two lamps give a status summary at a glance. One lamp tracks the tester's "test running" signal. The other lights when the first error record arrives and stays lit until reset. When the operator turns the view switch on, the display output shows one item of one stored record: a 3-bit item code and the item value as zero-extended hexadecimal digits. Each debounced press of the step button moves to the next item. After the last item of a record the view moves to the next record. After the newest record it wraps back to the oldest.

Top module: `errlog_view`

## Requirements
- R1: After reset, lamp_busy_o, lamp_err_o, ovf_o and disp_on_o are 0, and rec_ready_o is 1.
- R2: rec_ready_o stays 1. Each record offered with rec_valid_i high while the buffer is not full is stored, and records are presented in the order they arrived.
- R3: Once DEPTH records are stored, any further offered record is discarded and ovf_o goes to 1 and stays 1 until reset. The stored records are not changed.
- R4: lamp_err_o goes to 1 in the cycle after the first offered record, whether it is stored or dropped, and holds until reset.
- R5: lamp_busy_o follows test_active_i with one cycle of delay.
- R6: When the synchronised view switch is on and at least one record is stored, disp_on_o is 1. The view starts at the oldest record with item code 0.
- R7: The item codes are 0 error number, 1 address, 2 cycle count, 3 bad data and 4 test phase. Each press steps the code up by one. disp_val_o holds the selected item zero-extended to DIGITS*4 bits.
- R8: A press while code 4 is shown moves to code 0 of the next newer record. From the newest stored record it wraps to the oldest.
- R9: A button level that does not stay stable for DEB_CNT cycles after synchronisation causes no step.
- R10: While the view switch is off, disp_on_o, disp_fid_o and disp_val_o are all 0. Turning the switch on again starts from the oldest record, code 0.
- R11: With the switch on and the buffer empty, disp_on_o is 0 and presses have no effect. The first stored record then shows from code 0.
- R12: Records stored while viewing do not move the view position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_active_i | input | 1 | Tester reports a test in progress |
| rec_valid_i | input | 1 | Error record offered |
| rec_ready_o | output | 1 | Always 1; the tester is never stalled |
| rec_num_i | input | NUM_W | Error number |
| rec_addr_i | input | ADDR_W | Failing address |
| rec_cyc_i | input | CYC_W | Cycle count at failure |
| rec_data_i | input | DATA_W | Bad data read back |
| rec_part_i | input | PART_W | Test phase code |
| view_sw_i | input | 1 | Readout switch, asynchronous |
| step_btn_i | input | 1 | Step push button, raw and bouncing |
| lamp_busy_o | output | 1 | Testing-in-progress lamp |
| lamp_err_o | output | 1 | Sticky error-seen lamp |
| ovf_o | output | 1 | Sticky record-dropped flag |
| disp_on_o | output | 1 | Display shows a record item |
| disp_fid_o | output | 3 | Item code shown |
| disp_val_o | output | DIGITS*4 | Item value, hexadecimal digits |

## Verification
The hardest state to reach from the ports is the wrap from the last item of the newest record back to the oldest record, with a full buffer and one record already dropped. Each step needs a button level held past the debounce window and then released. The bench fills the buffer one record past its depth and presses through every item of every record. It checks each value against its own record table, and one more press must land on the oldest record. Before that, it steps partway into a record and stores a new record mid-view, to show that the position holds.

// File: rtl/elv_pkg.sv
package elv_pkg;

  typedef enum logic [2:0] {
    FID_NUM  = 3'd0,
    FID_ADDR = 3'd1,
    FID_CYC  = 3'd2,
    FID_DATA = 3'd3,
    FID_PART = 3'd4
  } fid_e;

  function automatic fid_e fid_next(input fid_e cur);
    case (cur)
      FID_NUM:  fid_next = FID_ADDR;
      FID_ADDR: fid_next = FID_CYC;
      FID_CYC:  fid_next = FID_DATA;
      FID_DATA: fid_next = FID_PART;
      default:  fid_next = FID_NUM;
    endcase
  endfunction

endpackage

// File: rtl/elv_sync_deb.sv
module elv_sync_deb #(
  parameter int DEB_CNT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o
);

  localparam int CNT_W = (DEB_CNT > 1) ? $clog2(DEB_CNT) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEB_CNT - 1);

  logic             s1_q, s2_q;
  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rise_q, rise_d;

  // stability counter: level accepted after DEB_CNT equal samples
  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (s2_q == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_MAX) begin
      cnt_d = '0;
      lvl_d = s2_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    rise_d = lvl_d & ~lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
      rise_q <= 1'b0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      lvl_q  <= lvl_d;
      cnt_q  <= cnt_d;
      rise_q <= rise_d;
    end
  end

  assign rise_o = rise_q;

  AST_STEP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R9

  AST_LEVEL_NEEDS_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_q == lvl_q) |=> $stable(lvl_q)); // R9

endmodule

// File: rtl/elv_store.sv
module elv_store #(
  parameter int DEPTH = 4,
  parameter int W     = 84
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic [W-1:0]                     wdata_i,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rd_idx_i,
  output logic [W-1:0]                     rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]       cnt_o,
  output logic                             ovf_o
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full;
  logic          wr_en;
  logic [IW-1:0] wr_idx;

  assign full   = (cnt_q == CNT_FULL);
  assign wr_en  = wr_i & ~full;
  assign wr_idx = cnt_q[IW-1:0];

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (wr_en)        cnt_d = cnt_q + 1'b1;
    if (wr_i && full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // storage array without reset, written with an explicit enable
  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_idx] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_idx_i];
  assign cnt_o   = cnt_q;
  assign ovf_o   = ovf_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL); // R3

  AST_DROP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full) |=> (ovf_q && $stable(cnt_q))); // R3

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R3

  AST_STORE_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !full) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

endmodule

// File: rtl/elv_cursor.sv
module elv_cursor
  import elv_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              en_i,
  input  logic                              adv_i,
  input  logic [$clog2(DEPTH+1)-1:0]        cnt_i,
  output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rec_o,
  output fid_e                              fid_o
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [IW-1:0] rec_q, rec_d;
  fid_e          fid_q, fid_d;
  logic          at_newest;

  assign at_newest = (CW'(rec_q) + CW'(1)) >= cnt_i;

  always_comb begin
    rec_d = rec_q;
    fid_d = fid_q;
    if (!en_i) begin
      rec_d = '0;
      fid_d = FID_NUM;
    end else if (adv_i) begin
      fid_d = fid_next(fid_q);
      if (fid_q == FID_PART) begin
        rec_d = at_newest ? '0 : rec_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q <= '0;
      fid_q <= FID_NUM;
    end else begin
      rec_q <= rec_d;
      fid_q <= fid_d;
    end
  end

  assign rec_o = rec_q;
  assign fid_o = fid_q;

  AST_FID_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fid_q <= FID_PART); // R7

  AST_REC_IN_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (CW'(rec_q) < cnt_i)); // R8

  AST_WRAP_OLDEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i && fid_q == FID_PART && at_newest) |=> (rec_q == '0 && fid_q == FID_NUM)); // R8

  AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !adv_i) |=> ($stable(rec_q) && $stable(fid_q))); // R12

  AST_OFF_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (rec_q == '0 && fid_q == FID_NUM)); // R10

endmodule

// File: rtl/errlog_view.sv
module errlog_view
  import elv_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int NUM_W   = 16,
  parameter int ADDR_W  = 16,
  parameter int CYC_W   = 32,
  parameter int DATA_W  = 16,
  parameter int PART_W  = 4,
  parameter int DIGITS  = 8,
  parameter int DEB_CNT = 1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  test_active_i,
  input  logic                  rec_valid_i,
  output logic                  rec_ready_o,
  input  logic [NUM_W-1:0]      rec_num_i,
  input  logic [ADDR_W-1:0]     rec_addr_i,
  input  logic [CYC_W-1:0]      rec_cyc_i,
  input  logic [DATA_W-1:0]     rec_data_i,
  input  logic [PART_W-1:0]     rec_part_i,
  input  logic                  view_sw_i,
  input  logic                  step_btn_i,
  output logic                  lamp_busy_o,
  output logic                  lamp_err_o,
  output logic                  ovf_o,
  output logic                  disp_on_o,
  output logic [2:0]            disp_fid_o,
  output logic [DIGITS*4-1:0]   disp_val_o
);

  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int VW    = DIGITS * 4;
  localparam int O_NUM  = 0;
  localparam int O_ADDR = O_NUM + NUM_W;
  localparam int O_CYC  = O_ADDR + ADDR_W;
  localparam int O_DATA = O_CYC + CYC_W;
  localparam int O_PART = O_DATA + DATA_W;
  localparam int REC_W  = O_PART + PART_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_i   <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_i   <= rst_m_q;
    end
  end

  // view switch synchroniser and lamps
  logic sw_m_q, sw_q;
  logic busy_q, busy_d;
  logic err_q, err_d;

  always_comb begin
    busy_d = test_active_i;
    err_d  = err_q | rec_valid_i;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sw_m_q <= 1'b0;
      sw_q   <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      sw_m_q <= view_sw_i;
      sw_q   <= sw_m_q;
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  // record storage
  logic [REC_W-1:0] wrec, rrec;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    rec_idx;
  logic             ovf;

  assign wrec = {rec_part_i, rec_data_i, rec_cyc_i, rec_addr_i, rec_num_i};

  elv_store #(
    .DEPTH (DEPTH),
    .W     (REC_W)
  ) u_store (
    .clk_i    (clk),
    .rst_ni   (rst_i),
    .wr_i     (rec_valid_i),
    .wdata_i  (wrec),
    .rd_idx_i (rec_idx),
    .rdata_o  (rrec),
    .cnt_o    (cnt),
    .ovf_o    (ovf)
  );

  // step button
  logic step_pulse;

  elv_sync_deb #(
    .DEB_CNT (DEB_CNT)
  ) u_deb (
    .clk_i  (clk),
    .rst_ni (rst_i),
    .raw_i  (step_btn_i),
    .rise_o (step_pulse)
  );

  // view position
  logic view_en;
  fid_e fid;

  assign view_en = sw_q & (cnt != '0);

  elv_cursor #(
    .DEPTH (DEPTH)
  ) u_cur (
    .clk_i  (clk),
    .rst_ni (rst_i),
    .en_i   (view_en),
    .adv_i  (step_pulse),
    .cnt_i  (cnt),
    .rec_o  (rec_idx),
    .fid_o  (fid)
  );

  // item select, zero-extended to the digit width
  logic [VW-1:0] val;
  always_comb begin
    val = '0;
    if (view_en) begin
      case (fid)
        FID_NUM:  val[NUM_W-1:0]  = rrec[O_NUM  +: NUM_W];
        FID_ADDR: val[ADDR_W-1:0] = rrec[O_ADDR +: ADDR_W];
        FID_CYC:  val[CYC_W-1:0]  = rrec[O_CYC  +: CYC_W];
        FID_DATA: val[DATA_W-1:0] = rrec[O_DATA +: DATA_W];
        default:  val[PART_W-1:0] = rrec[O_PART +: PART_W];
      endcase
    end
  end

  assign rec_ready_o = 1'b1;
  assign lamp_busy_o = busy_q;
  assign lamp_err_o  = err_q;
  assign ovf_o       = ovf;
  assign disp_on_o   = view_en;
  assign disp_fid_o  = view_en ? fid : FID_NUM;
  assign disp_val_o  = val;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_i)
    lamp_err_o |=> lamp_err_o); // R4

  AST_ERR_ON_REC: assert property (@(posedge clk) disable iff (!rst_i)
    rec_valid_i |=> lamp_err_o); // R4

  AST_BUSY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_i)
    test_active_i |=> lamp_busy_o); // R5

  AST_OVF_HAS_ERR: assert property (@(posedge clk) disable iff (!rst_i)
    ovf_o |-> lamp_err_o); // R3

endmodule

// File: tb/sim_errlog_view.sv
module sim_errlog_view;

  localparam int DEPTH = 4;
  localparam int DEB   = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        test_active, rec_valid, rec_ready;
  logic [15:0] r_num, r_addr, r_data;
  logic [31:0] r_cyc;
  logic [3:0]  r_part;
  logic        view_sw, step_btn;
  logic        lamp_busy, lamp_err, ovf, disp_on;
  logic [2:0]  disp_fid;
  logic [31:0] disp_val;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  errlog_view #(
    .DEPTH   (DEPTH),
    .DEB_CNT (DEB)
  ) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .test_active_i (test_active),
    .rec_valid_i   (rec_valid),
    .rec_ready_o   (rec_ready),
    .rec_num_i     (r_num),
    .rec_addr_i    (r_addr),
    .rec_cyc_i     (r_cyc),
    .rec_data_i    (r_data),
    .rec_part_i    (r_part),
    .view_sw_i     (view_sw),
    .step_btn_i    (step_btn),
    .lamp_busy_o   (lamp_busy),
    .lamp_err_o    (lamp_err),
    .ovf_o         (ovf),
    .disp_on_o     (disp_on),
    .disp_fid_o    (disp_fid),
    .disp_val_o    (disp_val)
  );

  function automatic logic [31:0] exp_item(input int i, input int f);
    case (f)
      0: exp_item = 32'(i + 1);
      1: exp_item = 32'(16'hA000 + i * 16'h0111);
      2: exp_item = 32'h0001_0000 * 32'(i + 3) + 32'(i);
      3: exp_item = 32'(16'hBEE0 + i);
      default: exp_item = 32'((i % 3) + 1);
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int i);
    @(negedge clk);
    rec_valid = 1'b1;
    r_num  = exp_item(i, 0)[15:0];
    r_addr = exp_item(i, 1)[15:0];
    r_cyc  = exp_item(i, 2);
    r_data = exp_item(i, 3)[15:0];
    r_part = exp_item(i, 4)[3:0];
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic press();
    step_btn = 1'b1;
    cyc(DEB + 6);
    step_btn = 1'b0;
    cyc(DEB + 6);
  endtask

  task automatic set_sw(input logic v);
    view_sw = v;
    cyc(4);
  endtask

  task automatic see(input string req, input int rec, input int f);
    chk(disp_on === 1'b1, req, {31'd0, disp_on}, 32'd1);
    chk(disp_fid === 3'(f), req, {29'd0, disp_fid}, 32'(f));
    chk(disp_val === exp_item(rec, f), req, disp_val, exp_item(rec, f));
  endtask

  task automatic t_reset();
    cyc(1);
    chk(lamp_busy === 1'b0, "R1", {31'd0, lamp_busy}, 0);
    chk(lamp_err === 1'b0, "R1", {31'd0, lamp_err}, 0);
    chk(ovf === 1'b0, "R1", {31'd0, ovf}, 0);
    chk(disp_on === 1'b0, "R1", {31'd0, disp_on}, 0);
    chk(rec_ready === 1'b1, "R1", {31'd0, rec_ready}, 1);
  endtask

  task automatic t_busy();
    test_active = 1'b1;
    cyc(1);
    chk(lamp_busy === 1'b1, "R5", {31'd0, lamp_busy}, 1);
    test_active = 1'b0;
    cyc(1);
    chk(lamp_busy === 1'b0, "R5", {31'd0, lamp_busy}, 0);
  endtask

  task automatic t_empty_view();
    set_sw(1'b1);
    chk(disp_on === 1'b0, "R11", {31'd0, disp_on}, 0);
    press();
    chk(disp_on === 1'b0, "R11", {31'd0, disp_on}, 0);
    push(0);
    chk(lamp_err === 1'b1, "R4", {31'd0, lamp_err}, 1);
    cyc(1);
    see("R11", 0, 0);
    see("R6", 0, 0);
  endtask

  task automatic t_mid_view_store();
    press();
    press();
    see("R7", 0, 2);
    push(1);
    cyc(1);
    see("R12", 0, 2);
    chk(rec_ready === 1'b1, "R2", {31'd0, rec_ready}, 1);
  endtask

  task automatic t_switch_off();
    set_sw(1'b0);
    chk(disp_on === 1'b0, "R10", {31'd0, disp_on}, 0);
    chk(disp_fid === 3'd0, "R10", {29'd0, disp_fid}, 0);
    chk(disp_val === 32'd0, "R10", disp_val, 0);
    set_sw(1'b1);
    see("R10", 0, 0);
  endtask

  task automatic t_overflow();
    push(2);
    push(3);
    chk(ovf === 1'b0, "R3", {31'd0, ovf}, 0);
    push(4);
    chk(ovf === 1'b1, "R3", {31'd0, ovf}, 1);
    cyc(3);
    chk(ovf === 1'b1, "R3", {31'd0, ovf}, 1);
    chk(lamp_err === 1'b1, "R4", {31'd0, lamp_err}, 1);
  endtask

  task automatic t_walk();
    for (int r = 0; r < DEPTH; r++) begin
      for (int f = 0; f < 5; f++) begin
        see((f == 0 && r > 0) ? "R8" : "R7", r, f);
        chk(disp_val === exp_item(r, f), "R2", disp_val, exp_item(r, f));
        press();
      end
    end
    see("R8", 0, 0);
    see("R3", 0, 0);
  endtask

  task automatic t_glitch();
    press();
    see("R9", 0, 1);
    step_btn = 1'b1;
    cyc(DEB - 4);
    step_btn = 1'b0;
    cyc(DEB + 6);
    see("R9", 0, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    test_active = 1'b0;
    rec_valid = 1'b0;
    r_num = '0; r_addr = '0; r_cyc = '0; r_data = '0; r_part = '0;
    view_sw = 1'b0;
    step_btn = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_busy();
    t_empty_view();
    t_mid_view_store();
    t_switch_off();
    t_overflow();
    t_walk();
    t_glitch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule